// File: doc/BRIEF.md
# Delay-Tap Drift Compensator

This block keeps two programmable delay taps tuned while process, supply and temperature move. It runs an on-chip ring-oscillator counter many times and averages the counts it reads back. It then rescales both tap settings by the ratio of a reference count to that average. The reference count is the value the oscillator gave when the taps were first tuned. A faster oscillator means shorter delay elements, so each tap needs more elements to keep the same delay in time.

One `start` pulse runs a full pass. The block writes the start bit of the counter register and polls that register until its done bit is set. It then adds the 8-bit count to a running sum. After a fixed number of measurements (ten by default) it divides the sum by that number. Next it reads the delay register, computes the two new tap values with one shared sequential divider, and writes the register back once. In that write every bit outside the two tap fields keeps its value. If the average is zero the delay register is not written and an error flag is raised.

Top module: `dly_calibrator`

## Requirements
- R1: While reset is held and on the first idle cycle after it, `busy`, `done`, `err`, `osc_wr` and `dly_wr` are all low.
- R2: A `start` pulse while idle begins a pass. `busy` is high from the next cycle until the cycle after `done`.
- R3: A pass issues exactly NUM_MEAS counter writes (default 10). Each write carries the value 0x4000, which is only bit 14 (the start bit) set. A new write is issued only after bit 15 (the done bit) of the counter register has been read back as set since the previous write.
- R4: Each measurement adds bits 7:0 of the counter register to a sum of at least 12 bits. Ten counts of 255 therefore sum to 2550 without overflow.
- R5: The average is the sum divided by NUM_MEAS, rounded down.
- R6: The new command tap in bits 4:0 is floor(old × reference / average), keeping only its low 5 bits.
- R7: The new feedback-clock tap in bits 12:8 is floor(old × reference / average), keeping only its low 5 bits.
- R8: A successful pass writes the delay register exactly once. Every bit outside 4:0 and 12:8 keeps the value it had in the cycle before the write.
- R9: An average of zero leaves the delay register unwritten and sets `err`. The next accepted `start` clears `err`.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: `done` is a single-cycle pulse at the end of each pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a calibration pass |
| ref_count | input | 8 | Oscillator count that the current taps were tuned for |
| osc_wr | output | 1 | Write strobe to the oscillator counter register |
| osc_wdata | output | 16 | Write data to the counter register (start bit 14) |
| osc_rdata | input | 16 | Counter register read value: count in 7:0, done in 15 |
| dly_rdata | input | 32 | Current delay register value |
| dly_wr | output | 1 | Write strobe to the delay register |
| dly_wdata | output | 32 | New delay register value |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| err | output | 1 | Last pass found a zero average |

## Verification
The assertions watch the handshake on every cycle. They check that no second trigger is issued while a measurement is still pending, that each trigger is the bare start word, and that a pass ends after exactly the set number of triggers. They also check that a delay write keeps the bits outside the two tap fields, that `done` lasts one cycle, and that an error never comes with a write. The arithmetic can only be shown by the bench's scenarios: the rounded-down average, the scaling ratio, and the wrap of an oversized result into its 5-bit field. The same holds for ignoring a second start and for clearing the error flag, which the bench drives with counter models of known counts and with varying done latency.

// File: rtl/dlycal_pkg.sv
package dlycal_pkg;

    // Measurement-loop sequencing
    typedef enum logic [1:0] {
        M_IDLE,
        M_TRIG,
        M_POLL
    } meas_state_t;

    // Rescale sequencing: capture, then one divide per tap field, then write
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD_GO,
        S_CMD_WAIT,
        S_FB_GO,
        S_FB_WAIT
    } scale_state_t;

    // Width of an accumulator that holds n samples of cw bits without wrap
    function automatic int sum_width(input int cw, input int n);
        return cw + $clog2(n);
    endfunction

endpackage

// File: rtl/dlycal_div.sv
// Restoring unsigned divider: one quotient bit per cycle.
module dlycal_div #(
    parameter int NUM_W = 13,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             valid,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_r;
    logic [DEN_W:0]   rem_r;
    logic [CNT_W-1:0] left_r;
    logic             run_r;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem_r[DEN_W-1:0], q_r[NUM_W-1]};
    assign fits  = trial >= {1'b0, den};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r    <= '0;
            rem_r  <= '0;
            left_r <= '0;
            run_r  <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                q_r    <= num;
                rem_r  <= '0;
                left_r <= CNT_W'(NUM_W);
                run_r  <= 1'b1;
            end else if (run_r) begin
                rem_r  <= fits ? (trial - {1'b0, den}) : trial;
                q_r    <= {q_r[NUM_W-2:0], fits};
                left_r <= left_r - 1'b1;
                if (left_r == CNT_W'(1)) begin
                    run_r <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quo = q_r;

endmodule

// File: rtl/dlycal_measure.sv
// Triggers the oscillator counter NUM_MEAS times and sums the counts.
module dlycal_measure
    import dlycal_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NUM_MEAS  = 10,
    parameter int OSC_W     = 16,
    parameter int START_BIT = 14,
    parameter int DONE_BIT  = 15,
    parameter int SUM_W     = sum_width(CNT_W, NUM_MEAS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [OSC_W-1:0] osc_rdata,
    output logic             osc_wr,
    output logic [OSC_W-1:0] osc_wdata,
    output logic [SUM_W-1:0] sum,
    output logic             done
);
    localparam int IDX_W = (NUM_MEAS > 1) ? $clog2(NUM_MEAS) : 1;
    localparam logic [OSC_W-1:0] START_WORD = OSC_W'(1) << START_BIT;

    meas_state_t      state;
    logic [IDX_W-1:0] idx;
    logic             sample_ok;

    assign sample_ok = osc_rdata[DONE_BIT];
    assign osc_wr    = (state == M_TRIG);
    assign osc_wdata = osc_wr ? START_WORD : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= M_IDLE;
            idx   <= '0;
            sum   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (go) begin
                        idx   <= '0;
                        sum   <= '0;
                        state <= M_TRIG;
                    end
                end
                M_TRIG: state <= M_POLL;
                M_POLL: begin
                    if (sample_ok) begin
                        sum <= sum + SUM_W'(osc_rdata[CNT_W-1:0]);
                        if (idx == IDX_W'(NUM_MEAS - 1)) begin
                            done  <= 1'b1;
                            state <= M_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= M_TRIG;
                        end
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    logic unused_rdata_bits;
    assign unused_rdata_bits = ^osc_rdata;

endmodule

// File: rtl/dlycal_rescale.sv
// Scales both tap fields by ref/avg and writes the register back once.
module dlycal_rescale
    import dlycal_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int FIELD_W = 5,
    parameter int REG_W   = 32,
    parameter int CMD_LSB = 0,
    parameter int FB_LSB  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] avg,
    input  logic [CNT_W-1:0] ref_count,
    input  logic [REG_W-1:0] dly_rdata,
    output logic             dly_wr,
    output logic [REG_W-1:0] dly_wdata,
    output logic             done,
    output logic             zero_div
);
    localparam int PROD_W = FIELD_W + CNT_W;

    scale_state_t        state;
    logic [CNT_W-1:0]    avg_q;
    logic [CNT_W-1:0]    ref_q;
    logic [FIELD_W-1:0]  cmd_old;
    logic [FIELD_W-1:0]  fb_old;
    logic [FIELD_W-1:0]  cmd_new;
    logic                div_go;
    logic [PROD_W-1:0]   div_num;
    logic                div_valid;
    logic [PROD_W-1:0]   div_quo;
    logic [REG_W-1:0]    merged;

    assign div_go  = (state == S_CMD_GO) || (state == S_FB_GO);
    assign div_num = (state == S_FB_GO) ? PROD_W'(fb_old) * PROD_W'(ref_q)
                                        : PROD_W'(cmd_old) * PROD_W'(ref_q);

    dlycal_div #(
        .NUM_W(PROD_W),
        .DEN_W(CNT_W)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (avg_q),
        .valid(div_valid),
        .quo  (div_quo)
    );

    always_comb begin
        merged = dly_rdata;
        merged[CMD_LSB +: FIELD_W] = cmd_new;
        merged[FB_LSB +: FIELD_W]  = div_quo[FIELD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            avg_q     <= '0;
            ref_q     <= '0;
            cmd_old   <= '0;
            fb_old    <= '0;
            cmd_new   <= '0;
            dly_wr    <= 1'b0;
            dly_wdata <= '0;
            done      <= 1'b0;
            zero_div  <= 1'b0;
        end else begin
            dly_wr   <= 1'b0;
            done     <= 1'b0;
            zero_div <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (go) begin
                        if (avg == '0) begin
                            done     <= 1'b1;
                            zero_div <= 1'b1;
                        end else begin
                            avg_q   <= avg;
                            ref_q   <= ref_count;
                            cmd_old <= dly_rdata[CMD_LSB +: FIELD_W];
                            fb_old  <= dly_rdata[FB_LSB +: FIELD_W];
                            state   <= S_CMD_GO;
                        end
                    end
                end
                S_CMD_GO: state <= S_CMD_WAIT;
                S_CMD_WAIT: begin
                    if (div_valid) begin
                        cmd_new <= div_quo[FIELD_W-1:0];
                        state   <= S_FB_GO;
                    end
                end
                S_FB_GO: state <= S_FB_WAIT;
                S_FB_WAIT: begin
                    if (div_valid) begin
                        dly_wdata <= merged;
                        dly_wr    <= 1'b1;
                        done      <= 1'b1;
                        state     <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    logic unused_quo_bits;
    assign unused_quo_bits = ^div_quo;

endmodule

// File: rtl/dly_calibrator.sv
module dly_calibrator
    import dlycal_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NUM_MEAS  = 10,
    parameter int OSC_W     = 16,
    parameter int START_BIT = 14,
    parameter int DONE_BIT  = 15,
    parameter int FIELD_W   = 5,
    parameter int REG_W     = 32,
    parameter int CMD_LSB   = 0,
    parameter int FB_LSB    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] ref_count,
    output logic             osc_wr,
    output logic [OSC_W-1:0] osc_wdata,
    input  logic [OSC_W-1:0] osc_rdata,
    input  logic [REG_W-1:0] dly_rdata,
    output logic             dly_wr,
    output logic [REG_W-1:0] dly_wdata,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam int SUM_W = sum_width(CNT_W, NUM_MEAS);

    logic             busy_q;
    logic             err_q;
    logic             accept;
    logic [SUM_W-1:0] meas_sum;
    logic             meas_done;
    logic [SUM_W-1:0] avg_full;
    logic [CNT_W-1:0] avg_q;
    logic             scale_go;
    logic             scale_done;
    logic             scale_zero;

    assign accept   = start && !busy_q;
    assign avg_full = meas_sum / SUM_W'(NUM_MEAS);

    dlycal_measure #(
        .CNT_W    (CNT_W),
        .NUM_MEAS (NUM_MEAS),
        .OSC_W    (OSC_W),
        .START_BIT(START_BIT),
        .DONE_BIT (DONE_BIT),
        .SUM_W    (SUM_W)
    ) u_meas (
        .clk      (clk),
        .rst      (rst),
        .go       (accept),
        .osc_rdata(osc_rdata),
        .osc_wr   (osc_wr),
        .osc_wdata(osc_wdata),
        .sum      (meas_sum),
        .done     (meas_done)
    );

    dlycal_rescale #(
        .CNT_W  (CNT_W),
        .FIELD_W(FIELD_W),
        .REG_W  (REG_W),
        .CMD_LSB(CMD_LSB),
        .FB_LSB (FB_LSB)
    ) u_scale (
        .clk      (clk),
        .rst      (rst),
        .go       (scale_go),
        .avg      (avg_q),
        .ref_count(ref_count),
        .dly_rdata(dly_rdata),
        .dly_wr   (dly_wr),
        .dly_wdata(dly_wdata),
        .done     (scale_done),
        .zero_div (scale_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            err_q    <= 1'b0;
            avg_q    <= '0;
            scale_go <= 1'b0;
        end else begin
            scale_go <= 1'b0;
            if (meas_done) begin
                avg_q    <= avg_full[CNT_W-1:0];
                scale_go <= 1'b1;
            end
            if (accept) begin
                busy_q <= 1'b1;
                err_q  <= 1'b0;
            end else if (scale_done) begin
                busy_q <= 1'b0;
            end
            if (scale_zero) err_q <= 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = scale_done;
    assign err  = err_q;

    logic unused_avg_bits;
    assign unused_avg_bits = ^avg_full;

endmodule

// File: rtl/dlycal_sva.sv
module dlycal_sva #(
    parameter int NUM_MEAS  = 10,
    parameter int OSC_W     = 16,
    parameter int START_BIT = 14,
    parameter int DONE_BIT  = 15,
    parameter int FIELD_W   = 5,
    parameter int REG_W     = 32,
    parameter int CMD_LSB   = 0,
    parameter int FB_LSB    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             osc_wr,
    input logic [OSC_W-1:0] osc_wdata,
    input logic [OSC_W-1:0] osc_rdata,
    input logic [REG_W-1:0] dly_rdata,
    input logic             dly_wr,
    input logic [REG_W-1:0] dly_wdata,
    input logic             busy,
    input logic             done,
    input logic             err
);
    localparam logic [REG_W-1:0] FIELD_MASK =
        (REG_W'((1 << FIELD_W) - 1) << CMD_LSB) | (REG_W'((1 << FIELD_W) - 1) << FB_LSB);
    localparam logic [OSC_W-1:0] START_WORD = OSC_W'(1) << START_BIT;

    logic [15:0] trig_cnt;
    logic        pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_cnt <= '0;
            pending  <= 1'b0;
        end else begin
            if (start && !busy)  trig_cnt <= '0;
            else if (osc_wr)     trig_cnt <= trig_cnt + 1'b1;
            if (osc_wr)                    pending <= 1'b1;
            else if (osc_rdata[DONE_BIT])  pending <= 1'b0;
        end
    end

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        osc_wr |-> !pending);
    a_r3_start_word: assert property (@(posedge clk) disable iff (rst)
        osc_wr |-> (osc_wdata == START_WORD));
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        osc_wr |=> !osc_wr);
    a_r3_trigger_total: assert property (@(posedge clk) disable iff (rst)
        done |-> (trig_cnt == 16'(NUM_MEAS)));
    a_r2_trig_in_pass: assert property (@(posedge clk) disable iff (rst)
        osc_wr |-> busy);
    a_r8_keep_bits: assert property (@(posedge clk) disable iff (rst)
        dly_wr |-> ((dly_wdata & ~FIELD_MASK) == ($past(dly_rdata) & ~FIELD_MASK)));
    a_r8_write_ends_pass: assert property (@(posedge clk) disable iff (rst)
        dly_wr |-> (done && busy));
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r9_err_no_write: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(done) && !$past(dly_wr)));
    a_r2_busy_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

endmodule

bind dly_calibrator dlycal_sva #(
    .NUM_MEAS (NUM_MEAS),
    .OSC_W    (OSC_W),
    .START_BIT(START_BIT),
    .DONE_BIT (DONE_BIT),
    .FIELD_W  (FIELD_W),
    .REG_W    (REG_W),
    .CMD_LSB  (CMD_LSB),
    .FB_LSB   (FB_LSB)
) u_sva (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .osc_wr   (osc_wr),
    .osc_wdata(osc_wdata),
    .osc_rdata(osc_rdata),
    .dly_rdata(dly_rdata),
    .dly_wr   (dly_wr),
    .dly_wdata(dly_wdata),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/dly_calibrator_test.sv
module dly_calibrator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  ref_count = '0;
    logic        osc_wr;
    logic [15:0] osc_wdata;
    logic [15:0] osc_rdata;
    logic [31:0] dly_rdata;
    logic        dly_wr;
    logic [31:0] dly_wdata;
    logic        busy;
    logic        done;
    logic        err;

    always #10 clk = ~clk;

    dly_calibrator uut (
        .clk(clk), .rst(rst), .start(start), .ref_count(ref_count),
        .osc_wr(osc_wr), .osc_wdata(osc_wdata), .osc_rdata(osc_rdata),
        .dly_rdata(dly_rdata), .dly_wr(dly_wr), .dly_wdata(dly_wdata),
        .busy(busy), .done(done), .err(err)
    );

    // Oscillator counter and delay register models
    logic [7:0]  m_base = '0;
    logic        m_inc = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] ld_val = '0;
    logic        osc_done_b;
    logic [7:0]  osc_val;
    logic [2:0]  timer;
    int          trig_n, wr_n, done_n, bad_word, overlap;
    logic [31:0] dreg;

    assign osc_rdata = {osc_done_b, 7'b0, osc_val};
    assign dly_rdata = dreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_done_b <= 1'b0; osc_val <= '0; timer <= '0;
            trig_n <= 0; wr_n <= 0; done_n <= 0; bad_word <= 0; overlap <= 0;
            dreg <= '0;
        end else if (clr) begin
            trig_n <= 0; wr_n <= 0; done_n <= 0; bad_word <= 0; overlap <= 0;
            dreg <= ld_val;
        end else begin
            if (osc_wr) begin
                if (osc_wdata != 16'h4000) bad_word <= bad_word + 1;
                if (timer != 0) overlap <= overlap + 1;
                osc_done_b <= 1'b0;
                timer <= 3'(2 + (trig_n % 3));
                osc_val <= m_base + (m_inc ? 8'(trig_n) : 8'd0);
                trig_n <= trig_n + 1;
            end else if (timer != 0) begin
                timer <= timer - 1'b1;
                if (timer == 3'd1) osc_done_b <= 1'b1;
            end
            if (dly_wr) begin
                dreg <= dly_wdata;
                wr_n <= wr_n + 1;
            end
            if (done) done_n <= done_n + 1;
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_pass(input logic [7:0] b, input logic inc, input logic [7:0] r,
                            input logic [31:0] init, input bit extra_start);
        int cyc;
        @(negedge clk);
        m_base = b; m_inc = inc; ref_count = r; ld_val = init; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy during pass", longint'(busy), 1);
        if (extra_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1;          // R10: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (done_n == 0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(done_n != 0, "R11 pass finished", longint'(done_n), 1);
        repeat (20) @(negedge clk);
        check(done_n == 1, "R11 done pulses", longint'(done_n), 1);
        check(busy == 1'b0, "R2 idle after pass", longint'(busy), 0);
        check(trig_n == 10, "R3 R10 trigger count", longint'(trig_n), 10);
        check(bad_word == 0, "R3 trigger word", longint'(bad_word), 0);
        check(overlap == 0, "R3 trigger overlap", longint'(overlap), 0);
    endtask

    typedef struct packed {
        logic [7:0]  base;
        logic        inc;
        logic [7:0]  refc;
        logic [31:0] init;
        logic [31:0] expect_v;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'd60,  1'b1, 8'd64,  32'h0000_0A13, 32'h0000_0A13},  // ratio 1
        '{8'd28,  1'b1, 8'd64,  32'hF0F0_E5E7, 32'hF0F0_EAEE},  // x2, keep bits
        '{8'd124, 1'b1, 8'd32,  32'h1234_1F1F, 32'h1234_0707},  // /4, floor
        '{8'd6,   1'b1, 8'd200, 32'h0000_0305, 32'h0000_1C04},  // wrap to 5 bits
        '{8'd246, 1'b1, 8'd1,   32'hFFFF_FFFF, 32'hFFFF_E0E0},  // to zero
        '{8'd255, 1'b0, 8'd255, 32'h0000_1F1F, 32'h0000_1F1F}   // max counts
    };

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && osc_wr == 0 && dly_wr == 0,
              "R1 in reset", longint'({busy, done, err, osc_wr, dly_wr}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && osc_wr == 0 && dly_wr == 0,
              "R1 after reset", longint'({busy, done, err, osc_wr, dly_wr}), 0);

        for (int v = 0; v < NV; v++) begin
            run_pass(VECS[v].base, VECS[v].inc, VECS[v].refc, VECS[v].init, v[0]);
            check(dreg == VECS[v].expect_v, "R4 R5 R6 R7 delay result",
                  longint'(dreg), longint'(VECS[v].expect_v));
            check(wr_n == 1, "R8 single write", longint'(wr_n), 1);
            check(err == 1'b0, "R9 no error", longint'(err), 0);
        end

        // Zero average: all counts 0
        run_pass(8'd0, 1'b0, 8'd50, 32'h0000_1F1F, 1'b0);
        check(err == 1'b1, "R9 error on zero average", longint'(err), 1);
        check(wr_n == 0, "R9 no write on zero average", longint'(wr_n), 0);
        check(dreg == 32'h0000_1F1F, "R9 delays unchanged", longint'(dreg), 32'h1F1F);

        // Following good pass clears the error
        run_pass(8'd28, 1'b1, 8'd64, 32'h0000_0307, 1'b0);
        check(err == 1'b0, "R9 error cleared", longint'(err), 0);
        check(dreg == 32'h0000_060E, "R6 R7 after error", longint'(dreg), 32'h060E);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule